// File: doc/BRIEF.md
# Three-level page table walker

This block turns a 32-bit virtual address into a 36-bit physical address by walking page tables that live in memory. The walk starts from a root table base held on an input. At each level the walker reads one 32-bit word over a request/acknowledge memory port and decodes the two-bit type in the low bits of that word. A pointer word leads to the next table. A leaf word ends the walk. An invalid or malformed word ends the walk with a fault. The virtual address is cut into an 8-bit first index, a 6-bit second index, a 6-bit third index and a 12-bit page offset. The tables therefore hold 256, 64 and 64 words.

When a leaf is reached, its 3-bit permission code is checked against the requested access. The access is read, write or execute, made by a user or a supervisor. A permitted access sets the referenced flag, and a write also sets the modified flag. If either flag changes, the updated leaf is written back to the word it came from before the result is given. A leaf found at the first or second level maps a 16 MiB or 256 KiB region. In that case the index fields below it are copied straight from the virtual address.

The walker handles one request at a time. It is built around a four-state machine:
- IDLE accepts a request and moves to READ.
- READ stays in READ on a pointer word at the first or second level. It moves to WBACK when a permitted leaf needs its flags written. Otherwise it moves to DONE: on a permitted leaf with no change, on any fault, or on the acknowledge of its read.
- WBACK moves to DONE on acknowledge.
- DONE shows the result for exactly one cycle and returns to IDLE.

Top module: `tblwalk_top`

## Requirements
- R1: The first read of a walk addresses `{root_ptp, 6'b0} + 4*va[31:24]`.
- R2: A pointer word (type 1, at the first or second level) gives the next table base `{word[31:2], 6'b0}`. The second read adds `4*va[23:18]` to that base, and the third read adds `4*va[17:12]`.
- R3: A leaf word (type 2) found at the third level gives `pa = {word[31:8], va[11:0]}`. In that case `cacheable` equals word bit 7, and `fault` is 0.
- R4: A leaf found at the first level gives `pa = {word[31:20], va[23:0]}`. A leaf found at the second level gives `pa = {word[31:14], va[17:0]}`. In both cases no further read is made.
- R5: A type-0 word ends the walk with `fault` = 1 and makes no write. On any fault, `pa` is 0 and `cacheable` is 0.
- R6: A type-3 word at any level, or a pointer word at the third level, ends the walk with `fault` = 2 and makes no write.
- R7: The permission code is word bits 4:2. User rights are 0 r, 1 rw, 2 rx, 3 rwx, 4 x, 5 r, 6 none, 7 none. Supervisor rights are 0 r, 1 rw, 2 rx, 3 rwx, 4 x, 5 rw, 6 rx, 7 rwx. `req_kind` encodes 0 as read, 1 as write, and 2 or 3 as execute. A denied access gives `fault` = 3 and leaves the word unchanged in memory.
- R8: A permitted access sets word bit 5 (referenced). If the bit was clear, exactly one write of the updated word goes to the leaf's own address before `done`. If the bit was already set on a read, no write is made.
- R9: A permitted write also sets word bit 6 (modified). The one write-back carries both bits set.
- R10: `done` is high for exactly one cycle per accepted request. A request is taken only while `req_ready` is high. A `req_valid` pulse while busy starts no walk.
- R11: `mem_req` stays high with a stable `mem_addr` and `mem_we` until `mem_ack`. `mem_we` is high only for the write-back.
- R12: After reset, `req_ready` is 1 and `mem_req` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| root_ptp | input | 30 | Root table base, physical address bits 35:6 |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request will be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | 0 read, 1 write, 2/3 execute |
| req_super | input | 1 | 1 for supervisor access |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 for write-back, 0 for read |
| mem_addr | output | 36 | Physical word address of the table entry |
| mem_wdata | output | 32 | Updated leaf word |
| mem_ack | input | 1 | Transfer completes in this cycle |
| mem_rdata | input | 32 | Read word, valid with `mem_ack` |
| done | output | 1 | Result valid this cycle |
| pa | output | 36 | Translated physical address |
| cacheable | output | 1 | Leaf cacheable bit |
| fault | output | 2 | 0 none, 1 invalid, 2 translation error, 3 protection |

## Verification
Every result is due in the cycle after the clock edge that takes the acknowledge of the walk's last transfer. That transfer is the final read, or the write-back when a flag changes. Results are gated so that they are valid only during that single `done` cycle. The bench drives and samples on falling edges. It polls for the first falling edge with `done` high and captures the outputs there. One falling edge later it checks that `done` has dropped. The memory model answers after one or three cycles, so that both latencies are exercised. The model logs every read and write address, and the bench compares them after the walk has settled.

// File: rtl/tblwalk_pkg.sv
package tblwalk_pkg;

    typedef enum logic [1:0] {
        ET_INVALID = 2'd0,
        ET_PTD     = 2'd1,
        ET_PTE     = 2'd2,
        ET_RESV    = 2'd3
    } etype_e;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_INVALID = 2'd1,
        FLT_XLATE   = 2'd2,
        FLT_PROT    = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_EXEC2 = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WBACK,
        ST_DONE
    } state_e;

    localparam int BIT_CACHE = 7;
    localparam int BIT_MOD   = 6;
    localparam int BIT_REF   = 5;
    localparam int ACC_LSB   = 2;
    localparam int ACC_W     = 3;
    localparam int ATTR_W    = 8;
    localparam int ET_W      = 2;

endpackage

// File: rtl/tblwalk_eaddr.sv
// Entry address for the table word of a given level.
module tblwalk_eaddr #(
    parameter int L1_W  = 8,
    parameter int L2_W  = 6,
    parameter int L3_W  = 6,
    parameter int PA_W  = 36,
    localparam int VPN_W = L1_W + L2_W + L3_W
) (
    input  logic [PA_W-1:0]  base,
    input  logic [1:0]       lvl,
    input  logic [VPN_W-1:0] vpn,
    output logic [PA_W-1:0]  ent_addr
);
    logic [PA_W-1:0] ofs;

    always_comb begin
        unique case (lvl)
            2'd0:    ofs = PA_W'(vpn[VPN_W-1 -: L1_W]) << 2;
            2'd1:    ofs = PA_W'(vpn[L3_W +: L2_W]) << 2;
            default: ofs = PA_W'(vpn[0 +: L3_W]) << 2;
        endcase
        ent_addr = base + ofs;
    end
endmodule

// File: rtl/tblwalk_pa.sv
// Physical address from a leaf page number, keeping untranslated low bits.
module tblwalk_pa #(
    parameter int L1_W  = 8,
    parameter int L2_W  = 6,
    parameter int L3_W  = 6,
    parameter int OFF_W = 12,
    parameter int PA_W  = 36,
    localparam int PPN_W = PA_W - OFF_W,
    localparam int LOW_W = L2_W + L3_W + OFF_W
) (
    input  logic [PPN_W-1:0] ppn,
    input  logic [1:0]       lvl,
    input  logic [LOW_W-1:0] va_low,
    output logic [PA_W-1:0]  pa
);
    localparam int KEEP_L1 = LOW_W;
    localparam int KEEP_L2 = L3_W + OFF_W;
    localparam int KEEP_L3 = OFF_W;

    logic [PA_W-1:0] keep_mask;
    logic [PA_W-1:0] full;

    always_comb begin
        unique case (lvl)
            2'd0:    keep_mask = (PA_W'(1) << KEEP_L1) - PA_W'(1);
            2'd1:    keep_mask = (PA_W'(1) << KEEP_L2) - PA_W'(1);
            default: keep_mask = (PA_W'(1) << KEEP_L3) - PA_W'(1);
        endcase
        full = {ppn, {OFF_W{1'b0}}};
        pa   = (full & ~keep_mask) | (PA_W'(va_low) & keep_mask);
    end
endmodule

// File: rtl/tblwalk_perm.sv
// Permission check: user and supervisor rights per access code.
module tblwalk_perm
    import tblwalk_pkg::*;
(
    input  logic [ACC_W-1:0] acc,
    input  logic             sup,
    input  kind_e            kind,
    output logic             ok
);
    logic [2:0] u_rwx;
    logic [2:0] s_rwx;
    logic [2:0] rwx;

    always_comb begin
        unique case (acc)
            3'd0: begin u_rwx = 3'b100; s_rwx = 3'b100; end
            3'd1: begin u_rwx = 3'b110; s_rwx = 3'b110; end
            3'd2: begin u_rwx = 3'b101; s_rwx = 3'b101; end
            3'd3: begin u_rwx = 3'b111; s_rwx = 3'b111; end
            3'd4: begin u_rwx = 3'b001; s_rwx = 3'b001; end
            3'd5: begin u_rwx = 3'b100; s_rwx = 3'b110; end
            3'd6: begin u_rwx = 3'b000; s_rwx = 3'b101; end
            default: begin u_rwx = 3'b000; s_rwx = 3'b111; end
        endcase
        rwx = sup ? s_rwx : u_rwx;
        unique case (kind)
            ACC_READ:  ok = rwx[2];
            ACC_WRITE: ok = rwx[1];
            default:   ok = rwx[0];
        endcase
    end

    always_comb begin
        if (kind == ACC_WRITE && !sup && acc == 3'd5)
            AST_USER5_NO_WRITE: assert (!ok) else $error("user write allowed on code 5"); // R7
    end
endmodule

// File: rtl/tblwalk_top.sv
module tblwalk_top #(
    parameter int L1_W  = 8,
    parameter int L2_W  = 6,
    parameter int L3_W  = 6,
    parameter int OFF_W = 12,
    parameter int PA_W  = 36,
    parameter int ENT_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ENT_W-3:0]          root_ptp,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [L1_W+L2_W+L3_W+OFF_W-1:0] req_vaddr,
    input  logic [1:0]                req_kind,
    input  logic                      req_super,
    output logic                      mem_req,
    output logic                      mem_we,
    output logic [PA_W-1:0]           mem_addr,
    output logic [ENT_W-1:0]          mem_wdata,
    input  logic                      mem_ack,
    input  logic [ENT_W-1:0]          mem_rdata,
    output logic                      done,
    output logic [PA_W-1:0]           pa,
    output logic                      cacheable,
    output logic [1:0]                fault
);
    import tblwalk_pkg::*;

    localparam int VA_W     = L1_W + L2_W + L3_W + OFF_W;
    localparam int VPN_W    = L1_W + L2_W + L3_W;
    localparam int LOW_W    = L2_W + L3_W + OFF_W;
    localparam int PTP_W    = ENT_W - ET_W;
    localparam int PTR_SH   = PA_W - PTP_W;
    localparam int PPN_W    = PA_W - OFF_W;
    localparam logic [1:0] LVL_LAST = 2'd2;

    // ---------------- state and data registers ----------------
    state_e            state_q, state_d;
    logic [VA_W-1:0]   va_q;
    kind_e             kind_q;
    logic              sup_q;
    logic [1:0]        lvl_q;
    logic [PA_W-1:0]   addr_q;
    logic [ENT_W-1:0]  wb_q;
    logic [PA_W-1:0]   pa_q;
    logic              c_q;
    fault_e            flt_q;

    // ---------------- decode of the returned word ----------------
    etype_e            et;
    logic              perm_ok;
    logic [ENT_W-1:0]  upd;
    logic              need_wb;
    logic              is_write;

    assign et       = etype_e'(mem_rdata[ET_W-1:0]);
    assign is_write = (kind_q == ACC_WRITE);
    assign upd      = mem_rdata
                    | (ENT_W'(1) << BIT_REF)
                    | (is_write ? (ENT_W'(1) << BIT_MOD) : '0);
    assign need_wb  = (upd != mem_rdata);

    // ---------------- entry address generator ----------------
    logic [PA_W-1:0]  ea_base;
    logic [1:0]       ea_lvl;
    logic [VPN_W-1:0] ea_vpn;
    logic [PA_W-1:0]  ea_addr;

    always_comb begin
        if (state_q == ST_IDLE) begin
            ea_base = {root_ptp, {PTR_SH{1'b0}}};
            ea_lvl  = 2'd0;
            ea_vpn  = req_vaddr[VA_W-1:OFF_W];
        end else begin
            ea_base = {mem_rdata[ENT_W-1:ET_W], {PTR_SH{1'b0}}};
            ea_lvl  = lvl_q + 2'd1;
            ea_vpn  = va_q[VA_W-1:OFF_W];
        end
    end

    tblwalk_eaddr #(
        .L1_W(L1_W), .L2_W(L2_W), .L3_W(L3_W), .PA_W(PA_W)
    ) u_eaddr (
        .base     (ea_base),
        .lvl      (ea_lvl),
        .vpn      (ea_vpn),
        .ent_addr (ea_addr)
    );

    // ---------------- leaf address and permission ----------------
    logic [PA_W-1:0] leaf_pa;

    tblwalk_pa #(
        .L1_W(L1_W), .L2_W(L2_W), .L3_W(L3_W), .OFF_W(OFF_W), .PA_W(PA_W)
    ) u_pa (
        .ppn    (mem_rdata[ENT_W-1 -: PPN_W]),
        .lvl    (lvl_q),
        .va_low (va_q[LOW_W-1:0]),
        .pa     (leaf_pa)
    );

    tblwalk_perm u_perm (
        .acc  (mem_rdata[ACC_LSB +: ACC_W]),
        .sup  (sup_q),
        .kind (kind_q),
        .ok   (perm_ok)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_READ;
            ST_READ: begin
                if (mem_ack) begin
                    unique case (et)
                        ET_PTD:  if (lvl_q == LVL_LAST) state_d = ST_DONE;
                        ET_PTE:  state_d = (perm_ok && need_wb) ? ST_WBACK : ST_DONE;
                        default: state_d = ST_DONE;
                    endcase
                end
            end
            ST_WBACK: if (mem_ack) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
        endcase
    end

    // ---------------- walk data ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q   <= '0;
            kind_q <= ACC_READ;
            sup_q  <= 1'b0;
            lvl_q  <= 2'd0;
            addr_q <= '0;
            wb_q   <= '0;
            pa_q   <= '0;
            c_q    <= 1'b0;
            flt_q  <= FLT_NONE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q   <= req_vaddr;
                        kind_q <= kind_e'(req_kind);
                        sup_q  <= req_super;
                        lvl_q  <= 2'd0;
                        addr_q <= ea_addr;
                        pa_q   <= '0;
                        c_q    <= 1'b0;
                        flt_q  <= FLT_NONE;
                    end
                end
                ST_READ: begin
                    if (mem_ack) begin
                        unique case (et)
                            ET_PTD: begin
                                if (lvl_q == LVL_LAST) begin
                                    flt_q <= FLT_XLATE;
                                end else begin
                                    lvl_q  <= lvl_q + 2'd1;
                                    addr_q <= ea_addr;
                                end
                            end
                            ET_PTE: begin
                                if (!perm_ok) begin
                                    flt_q <= FLT_PROT;
                                end else begin
                                    pa_q <= leaf_pa;
                                    c_q  <= mem_rdata[BIT_CACHE];
                                    wb_q <= upd;
                                end
                            end
                            ET_INVALID: flt_q <= FLT_INVALID;
                            default:    flt_q <= FLT_XLATE;
                        endcase
                    end
                end
                default: ;
            endcase
        end
    end

    // ---------------- outputs ----------------
    assign mem_addr  = addr_q;
    assign mem_wdata = wb_q;

    always_comb begin
        req_ready = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        done      = 1'b0;
        pa        = '0;
        cacheable = 1'b0;
        fault     = FLT_NONE;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_READ:  mem_req = 1'b1;
            ST_WBACK: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            ST_DONE: begin
                done      = 1'b1;
                pa        = pa_q;
                cacheable = c_q;
                fault     = flt_q;
            end
        endcase
    end

    // ---------------- assertions ----------------
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done held longer than one cycle"); // R10

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)))
        else $error("memory request dropped or changed before ack"); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req && !done)) else $error("activity while idle"); // R12

    AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault != 2'd0) |-> (pa == '0 && !cacheable))
        else $error("address shown with a fault"); // R5

    AST_WB_REF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[BIT_REF]) else $error("write-back without referenced bit"); // R8

    AST_WB_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (done && fault == 2'd0))
        else $error("write-back not followed by a clean result"); // R8

endmodule

// File: tb/tb_tblwalk_top.sv
module tb_tblwalk_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [29:0] root_ptp;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_vaddr;
    logic [1:0]  req_kind;
    logic        req_super;
    logic        mem_req;
    logic        mem_we;
    logic [35:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack;
    logic [31:0] mem_rdata;
    logic        done;
    logic [35:0] pa;
    logic        cacheable;
    logic [1:0]  fault;

    always #5 clk = ~clk;

    tblwalk_top dut (
        .clk(clk), .rst_n(rst_n), .root_ptp(root_ptp),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .req_super(req_super),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .pa(pa), .cacheable(cacheable), .fault(fault)
    );

    // memory and logs
    logic [31:0] mem [logic [35:0]];
    logic [35:0] rd_log [0:7];
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    logic [35:0] wr_addr;
    logic [31:0] wr_data;
    int          lat = 1;

    int n_chk = 0;
    int n_bad = 0;

    // walk results
    logic [35:0] r_pa;
    logic        r_c;
    logic [1:0]  r_f;
    int          rd0, wr0;

    localparam logic [35:0] ROOT = 36'h1_0000_0000;
    localparam logic [35:0] L2A  = 36'h2_0000_0000;
    localparam logic [35:0] L3A  = 36'h3_0000_0400;

    function automatic logic [31:0] rd_mem(input logic [35:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic logic [31:0] mk_ptd(input logic [35:0] base);
        return {base[35:6], 2'b01};
    endfunction

    function automatic logic [31:0] mk_pte(input logic [23:0] ppn, input bit c, m, r,
                                           input logic [2:0] acc);
        return {ppn, c, m, r, acc, 2'b10};
    endfunction

    function automatic logic [35:0] ent(input logic [35:0] base, input int idx);
        return base + 36'(idx) * 36'd4;
    endfunction

    function automatic bit allowed(input int acc, input bit sup, input int kind);
        bit r, w, x;
        r = (acc != 4);
        w = acc[0];
        x = acc[1] || (acc == 4);
        if (!sup) begin
            if (acc >= 6) begin r = 0; w = 0; x = 0; end
            else if (acc == 5) w = 0;
        end
        return (kind == 0) ? r : (kind == 1) ? w : x;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic mem_model();
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                mem_ack = 1'b0;
                cnt = 0;
            end else if (mem_ack) begin
                mem_ack = 1'b0;
                cnt = 0;
            end else if (mem_req) begin
                cnt++;
                if (cnt >= lat) begin
                    mem_ack = 1'b1;
                    if (mem_we) begin
                        mem[mem_addr] = mem_wdata;
                        wr_cnt++;
                        wr_addr = mem_addr;
                        wr_data = mem_wdata;
                    end else begin
                        mem_rdata = rd_mem(mem_addr);
                        if (rd_cnt < 8) rd_log[rd_cnt] = mem_addr;
                        rd_cnt++;
                    end
                end
            end
        end
    endtask

    task automatic watchdog();
        repeat (100000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Issue one request, wait for done, capture result, check the pulse ends.
    task automatic walk(input logic [31:0] va, input logic [1:0] kind, input bit sup);
        bit seen = 0;
        rd0 = rd_cnt;
        wr0 = wr_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_super = sup;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 200; i++) begin
            if (done) begin seen = 1; break; end
            @(negedge clk);
        end
        chk("R10 done seen", 64'(seen), 64'd1);
        r_pa = pa; r_c = cacheable; r_f = fault;
        @(negedge clk);
        chk("R10 done one cycle", 64'(done), 64'd0);
    endtask

    // ---------------- scenarios ----------------
    logic [7:0]  i1;
    logic [5:0]  i2, i3;
    logic [11:0] off;
    logic [31:0] va_main;

    task automatic t_reset();
        chk("R12 ready after reset", 64'(req_ready), 64'd1);
        chk("R12 no mem_req after reset", 64'(mem_req), 64'd0);
        chk("R12 no done after reset", 64'(done), 64'd0);
    endtask

    task automatic t_l3_read_first();
        logic [31:0] leaf = mk_pte(24'hABCDE1, 1, 0, 0, 3'd0);
        mem[ent(ROOT, i1)] = mk_ptd(L2A);
        mem[ent(L2A, i2)]  = mk_ptd(L3A);
        mem[ent(L3A, i3)]  = leaf;
        lat = 3;
        walk(va_main, 2'd0, 1'b0);
        chk("R3 pa level 3", 64'(r_pa), 64'({24'hABCDE1, off}));
        chk("R3 cacheable", 64'(r_c), 64'd1);
        chk("R3 fault none", 64'(r_f), 64'd0);
        chk("R1 read count", 64'(rd_cnt - rd0), 64'd3);
        chk("R1 first address", 64'(rd_log[rd0]), 64'(ent(ROOT, i1)));
        chk("R2 second address", 64'(rd_log[rd0 + 1]), 64'(ent(L2A, i2)));
        chk("R2 third address", 64'(rd_log[rd0 + 2]), 64'(ent(L3A, i3)));
        chk("R8 one write-back", 64'(wr_cnt - wr0), 64'd1);
        chk("R8 write-back address", 64'(wr_addr), 64'(ent(L3A, i3)));
        chk("R8 write-back data", 64'(wr_data), 64'(leaf | 32'h20));
    endtask

    task automatic t_l3_read_again();
        lat = 1;
        walk(va_main, 2'd0, 1'b1);
        chk("R8 no write when referenced set", 64'(wr_cnt - wr0), 64'd0);
        chk("R3 pa repeat", 64'(r_pa), 64'({24'hABCDE1, off}));
    endtask

    task automatic t_write_sets_mod();
        logic [5:0] iw = 6'h2A;
        logic [31:0] leaf = mk_pte(24'h135791, 0, 0, 1, 3'd1);
        mem[ent(L3A, iw)] = leaf;
        walk({i1, i2, iw, 12'h0FE}, 2'd1, 1'b0);
        chk("R9 write fault none", 64'(r_f), 64'd0);
        chk("R9 write pa", 64'(r_pa), 64'({24'h135791, 12'h0FE}));
        chk("R3 cacheable clear", 64'(r_c), 64'd0);
        chk("R9 one write-back", 64'(wr_cnt - wr0), 64'd1);
        chk("R9 modified set", 64'(wr_data), 64'(leaf | 32'h40));
    endtask

    task automatic t_super_l1();
        logic [7:0] ib = 8'hC3;
        logic [31:0] leaf = mk_pte(24'h9F1234, 0, 1, 1, 3'd3);
        logic [31:0] va = {ib, 24'h5A5A5A};
        mem[ent(ROOT, ib)] = leaf;
        walk(va, 2'd2, 1'b1);
        chk("R4 level-1 pa", 64'(r_pa), 64'({12'h9F1, 24'h5A5A5A}));
        chk("R4 level-1 single read", 64'(rd_cnt - rd0), 64'd1);
        chk("R4 level-1 no write", 64'(wr_cnt - wr0), 64'd0);
    endtask

    task automatic t_super_l2();
        logic [7:0] ic = 8'h11;
        logic [5:0] jc = 6'h05;
        logic [35:0] l2b = 36'h2_0000_1000;
        logic [31:0] leaf = mk_pte(24'h777777, 1, 0, 0, 3'd1);
        logic [31:0] va = {ic, jc, 18'h2C3A5};
        mem[ent(ROOT, ic)] = mk_ptd(l2b);
        mem[ent(l2b, jc)]  = leaf;
        lat = 3;
        walk(va, 2'd1, 1'b0);
        lat = 1;
        chk("R4 level-2 pa", 64'(r_pa), 64'({18'(24'h777777 >> 6), 18'h2C3A5}));
        chk("R4 level-2 reads", 64'(rd_cnt - rd0), 64'd2);
        chk("R9 level-2 write-back", 64'(wr_data), 64'(leaf | 32'h60));
        chk("R9 level-2 write address", 64'(wr_addr), 64'(ent(l2b, jc)));
    endtask

    task automatic t_invalid();
        walk({8'h22, 24'h000123}, 2'd0, 1'b1);
        chk("R5 invalid fault", 64'(r_f), 64'd1);
        chk("R5 pa zero", 64'(r_pa), 64'd0);
        chk("R5 one read", 64'(rd_cnt - rd0), 64'd1);
        chk("R5 no write", 64'(wr_cnt - wr0), 64'd0);
    endtask

    task automatic t_reserved_l2();
        logic [35:0] l2b = 36'h2_0000_2000;
        mem[ent(ROOT, 8'h33)] = mk_ptd(l2b);
        mem[ent(l2b, 6'h09)]  = 32'hFFFF_FF03;
        walk({8'h33, 6'h09, 18'h0}, 2'd0, 1'b1);
        chk("R6 reserved fault", 64'(r_f), 64'd2);
        chk("R6 reserved reads", 64'(rd_cnt - rd0), 64'd2);
        chk("R6 reserved no write", 64'(wr_cnt - wr0), 64'd0);
    endtask

    task automatic t_ptd_l3();
        logic [35:0] l2b = 36'h2_0000_3000;
        logic [35:0] l3b = 36'h3_0000_8000;
        mem[ent(ROOT, 8'h44)] = mk_ptd(l2b);
        mem[ent(l2b, 6'h01)]  = mk_ptd(l3b);
        mem[ent(l3b, 6'h3F)]  = mk_ptd(36'h4_0000_0000);
        walk({8'h44, 6'h01, 6'h3F, 12'hFFF}, 2'd0, 1'b1);
        chk("R6 pointer at level 3 fault", 64'(r_f), 64'd2);
        chk("R6 pointer at level 3 reads", 64'(rd_cnt - rd0), 64'd3);
        chk("R5 cacheable zero on fault", 64'(r_c), 64'd0);
    endtask

    task automatic t_perm_table();
        logic [5:0] ip = 6'h31;
        for (int acc = 0; acc < 8; acc++) begin
            for (int s = 0; s < 2; s++) begin
                for (int k = 0; k < 4; k++) begin
                    mem[ent(L3A, ip)] = mk_pte(24'h000FAB, 1, 1, 1, 3'(acc));
                    walk({i1, i2, ip, 12'h010}, 2'(k), 1'(s));
                    chk($sformatf("R7 acc=%0d sup=%0d kind=%0d", acc, s, k),
                        64'(r_f), allowed(acc, 1'(s), (k == 3) ? 2 : k) ? 64'd0 : 64'd3);
                    chk("R8 no write when flags set", 64'(wr_cnt - wr0), 64'd0);
                end
            end
        end
    endtask

    task automatic t_prot_no_update();
        logic [5:0] iq = 6'h32;
        logic [31:0] leaf = mk_pte(24'h00BEEF, 1, 0, 0, 3'd6);
        mem[ent(L3A, iq)] = leaf;
        walk({i1, i2, iq, 12'h0}, 2'd0, 1'b0);
        chk("R7 user denied fault", 64'(r_f), 64'd3);
        chk("R7 no write on protection fault", 64'(wr_cnt - wr0), 64'd0);
        chk("R7 word unchanged", 64'(rd_mem(ent(L3A, iq))), 64'(leaf));
    endtask

    task automatic t_busy_ignored();
        bit seen = 0;
        lat = 3;
        rd0 = rd_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va_main; req_kind = 2'd0; req_super = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R10 not ready while busy", 64'(req_ready), 64'd0);
        req_valid = 1'b1; req_vaddr = {8'h22, 24'h0}; req_kind = 2'd0;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 200; i++) begin
            if (done) begin seen = 1; break; end
            @(negedge clk);
        end
        chk("R10 busy walk done", 64'(seen), 64'd1);
        chk("R10 first request result", 64'(pa), 64'({24'hABCDE1, off}));
        chk("R10 first request fault", 64'(fault), 64'd0);
        repeat (8) @(negedge clk);
        chk("R10 no second walk", 64'(rd_cnt - rd0), 64'd3);
        chk("R10 idle afterwards", 64'(req_ready), 64'd1);
        lat = 1;
    endtask

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0; req_vaddr = '0; req_kind = '0; req_super = 1'b0;
        mem_ack = 1'b0; mem_rdata = '0;
        root_ptp = ROOT[35:6];
        i1 = 8'h5A; i2 = 6'h23; i3 = 6'h15; off = 12'h678;
        va_main = {i1, i2, i3, off};
        fork
            mem_model();
            watchdog();
        join_none
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_l3_read_first();
        t_l3_read_again();
        t_write_sets_mod();
        t_super_l1();
        t_super_l2();
        t_invalid();
        t_reserved_l2();
        t_ptd_l3();
        t_perm_table();
        t_prot_no_update();
        t_busy_ignored();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule